// File: doc/BRIEF.md
# Weighted Duty-Cycle Accumulator

This block estimates how much of the time a one-bit magnitude signal spends high. On each cycle where the sample enable is asserted, it takes a negative weight into a signed running sum. The weight is -3 when the magnitude bit is high and -1 when it is low. The block also counts how many samples were taken. From the sum ACC and the count N, the high-time fraction is N_high / N = -(N + ACC) / (2N). For a nominal 30 % duty cycle the sum settles near -1.6·N. The only deviation comes from partial samples at the start and end of the window.

A dump strobe ends the integration window. On the dump cycle, the live sum and the live count are copied into holding registers. A sample that arrives in the same cycle is included in that copy, and the live sum and count then restart from zero. A two-state controller (`ST_INTEGRATE`, `ST_PUBLISH`) moves to `ST_PUBLISH` on a dump (transition "dump seen"). One cycle later it registers the numerator -(N+ACC) and the denominator 2N, and raises a one-cycle result-valid pulse. It returns to `ST_INTEGRATE` when no new dump is present (transition "publish done"). It stays in `ST_PUBLISH` when another dump arrives (transition "dump again"). The sum and the count both saturate rather than wrap. This keeps very long windows from producing meaningless ratios.

Top module: `dcm_duty_meter`

## Requirements
- R1: While reset is asserted, and after it is released, every output is zero and the result-valid pulse is low, until the first dump has been processed.
- R2: Each enabled sample with the magnitude bit high lowers the live sum by 3.
- R3: Each enabled sample with the magnitude bit low lowers the live sum by 1.
- R4: A cycle without sample enable changes neither the live sum nor the live count, whatever the magnitude bit does.
- R5: On a dump edge, the held sum output takes the live sum including that cycle's sample (when enabled), and the next window starts from zero.
- R6: On a dump edge, the held count output takes the number of enabled samples in the window, including that cycle's sample.
- R7: The live sum saturates at the most negative value of its signed width (-2^(ACC_W-1)) and never wraps to a positive value.
- R8: The live count saturates at 2^CNT_W - 1 and holds there until the next dump.
- R9: One clock after the held values change on a dump, the numerator output equals -(count + sum) and the denominator output equals 2·count. Both hold until the next publish.
- R10: The result-valid pulse is high for exactly one cycle, two edges after each dump. Dumps on consecutive cycles give pulses on consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en_i | input | 1 | Take one sample this cycle |
| mag_i | input | 1 | Magnitude bit being measured |
| dump_i | input | 1 | End the integration window this cycle |
| acc_o | output | ACC_W | Held signed weighted sum of the last window |
| cnt_o | output | CNT_W | Held sample count of the last window |
| num_o | output | ACC_W+1 | Signed numerator -(count + sum), equal to 2·N_high |
| den_o | output | CNT_W+1 | Denominator 2·count |
| res_valid_o | output | 1 | One-cycle pulse when numerator and denominator are new |

## Verification
The hardest condition to reach from the ports is saturation. At the default widths the sum needs millions of samples before it reaches its floor, and the count needs even more. The bench therefore instantiates the block with narrow widths (a 10-bit sum and a 9-bit count). Long all-high runs then drive the sum into its floor, and long all-low runs drive the count into its ceiling, within a few hundred cycles. Back-to-back dumps exercise the `ST_PUBLISH` self-loop. A dump on the same cycle as a sample exercises the rule that the closing sample is included in the result.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

    typedef enum logic [0:0] {
        ST_INTEGRATE = 1'b0,
        ST_PUBLISH   = 1'b1
    } dcm_state_e;

endpackage

// File: rtl/dcm_weight_accum.sv
module dcm_weight_accum #(
    parameter int ACC_W     = 24,
    parameter int HI_WEIGHT = 3,
    parameter int LO_WEIGHT = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_en_i,
    input  logic                    mag_i,
    input  logic                    restart_i,
    output logic signed [ACC_W-1:0] sum_next_o
);
    localparam int EXT_W = ACC_W + 1;
    localparam logic signed [EXT_W-1:0] W_HI   = EXT_W'(HI_WEIGHT);
    localparam logic signed [EXT_W-1:0] W_LO   = EXT_W'(LO_WEIGHT);
    localparam logic signed [EXT_W-1:0] FLOOR  = -(EXT_W'(1) <<< (ACC_W - 1));

    logic signed [ACC_W-1:0] sum_q;
    logic signed [EXT_W-1:0] trial;

    always_comb begin
        trial = {sum_q[ACC_W-1], sum_q};
        if (sample_en_i) begin
            trial = trial - (mag_i ? W_HI : W_LO);
        end
        if (trial < FLOOR) begin
            sum_next_o = FLOOR[ACC_W-1:0];
        end else begin
            sum_next_o = trial[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
        end else if (restart_i) begin
            sum_q <= '0;
        end else begin
            sum_q <= sum_next_o;
        end
    end

    // R7: weights are negative, so the live sum never turns positive
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (sum_q[ACC_W-1] || sum_q == '0));

    // R4: an idle cycle leaves the live sum untouched
    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_en_i && !restart_i) |=> $stable(sum_q));

endmodule

// File: rtl/dcm_sample_count.sv
module dcm_sample_count #(
    parameter int CNT_W = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_en_i,
    input  logic             restart_i,
    output logic [CNT_W-1:0] cnt_next_o
);
    localparam logic [CNT_W-1:0] CEIL = '1;

    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cnt_next_o = cnt_q;
        if (sample_en_i && cnt_q != CEIL) begin
            cnt_next_o = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_next_o;
        end
    end

    // R8: once at the ceiling the count stays there until restarted
    a_r8_cnt_hold_at_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CEIL && !restart_i) |=> cnt_q == CEIL);

endmodule

// File: rtl/dcm_ratio_terms.sv
module dcm_ratio_terms #(
    parameter int ACC_W = 24,
    parameter int CNT_W = 23
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic signed [ACC_W-1:0] held_sum_i,
    input  logic [CNT_W-1:0]        held_cnt_i,
    output logic signed [ACC_W:0]   num_o,
    output logic [CNT_W:0]          den_o
);
    localparam int NUM_W = ACC_W + 1;

    logic signed [NUM_W-1:0] cnt_ext;
    logic signed [NUM_W-1:0] sum_ext;
    logic signed [NUM_W-1:0] num_d;

    always_comb begin
        cnt_ext = {{(NUM_W - CNT_W){1'b0}}, held_cnt_i};
        sum_ext = {held_sum_i[ACC_W-1], held_sum_i};
        num_d   = -(cnt_ext + sum_ext);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            num_o <= '0;
            den_o <= '0;
        end else if (load_i) begin
            num_o <= num_d;
            den_o <= {held_cnt_i, 1'b0};
        end
    end

endmodule

// File: rtl/dcm_duty_meter.sv
module dcm_duty_meter #(
    parameter int ACC_W     = 24,
    parameter int CNT_W     = 23,
    parameter int HI_WEIGHT = 3,
    parameter int LO_WEIGHT = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_en_i,
    input  logic                    mag_i,
    input  logic                    dump_i,
    output logic signed [ACC_W-1:0] acc_o,
    output logic [CNT_W-1:0]        cnt_o,
    output logic signed [ACC_W:0]   num_o,
    output logic [CNT_W:0]          den_o,
    output logic                    res_valid_o
);
    import dcm_pkg::*;

    localparam bit WIDTHS_OK = (CNT_W < ACC_W);

    dcm_state_e              state_q, state_d;
    logic signed [ACC_W-1:0] sum_next;
    logic [CNT_W-1:0]        cnt_next;
    logic                    publish;

    generate
        if (!WIDTHS_OK) begin : g_bad_widths
            initial $error("CNT_W must be smaller than ACC_W");
        end
    endgenerate

    dcm_weight_accum #(
        .ACC_W    (ACC_W),
        .HI_WEIGHT(HI_WEIGHT),
        .LO_WEIGHT(LO_WEIGHT)
    ) u_accum (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_en_i(sample_en_i),
        .mag_i      (mag_i),
        .restart_i  (dump_i),
        .sum_next_o (sum_next)
    );

    dcm_sample_count #(
        .CNT_W(CNT_W)
    ) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_en_i(sample_en_i),
        .restart_i  (dump_i),
        .cnt_next_o (cnt_next)
    );

    dcm_ratio_terms #(
        .ACC_W(ACC_W),
        .CNT_W(CNT_W)
    ) u_terms (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (publish),
        .held_sum_i(acc_o),
        .held_cnt_i(cnt_o),
        .num_o     (num_o),
        .den_o     (den_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INTEGRATE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and decoded controls
    always_comb begin
        state_d = state_q;
        publish = 1'b0;
        unique case (state_q)
            ST_INTEGRATE: begin
                if (dump_i) state_d = ST_PUBLISH;        // dump seen
            end
            ST_PUBLISH: begin
                publish = 1'b1;
                state_d = dump_i ? ST_PUBLISH            // dump again
                                 : ST_INTEGRATE;         // publish done
            end
            default: state_d = ST_INTEGRATE;
        endcase
    end

    // outputs: held window values and result pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_o       <= '0;
            cnt_o       <= '0;
            res_valid_o <= 1'b0;
        end else begin
            res_valid_o <= publish;
            if (dump_i) begin
                acc_o <= sum_next;
                cnt_o <= cnt_next;
            end
        end
    end

    // R10: every pulse traces back to a dump two edges earlier
    a_r10_valid_needs_dump: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> $past(dump_i, 2));

    // R10: a dump always yields a pulse two edges later
    a_r10_dump_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
        dump_i |=> ##1 res_valid_o);

    // R9: the numerator equals 2*N_high and cannot be negative
    a_r9_num_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid_o |-> !num_o[ACC_W]);

    // R9: numerator and denominator stay put between pulses
    a_r9_terms_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid_o |-> ($stable(num_o) && $stable(den_o)));

endmodule

// File: tb/tb_dcm_duty_meter.sv
module tb_dcm_duty_meter;
    localparam int AW = 10;
    localparam int CW = 9;
    localparam longint FLOOR = -(64'sd1 <<< (AW - 1));
    localparam longint CEIL  = (64'sd1 <<< CW) - 1;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 sample_en_i = 1'b0;
    logic                 mag_i = 1'b0;
    logic                 dump_i = 1'b0;
    logic signed [AW-1:0] acc_o;
    logic [CW-1:0]        cnt_o;
    logic signed [AW:0]   num_o;
    logic [CW:0]          den_o;
    logic                 res_valid_o;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 1'b0;
    string phase = "R1";

    // reference model state
    longint m_live_sum = 0, m_live_cnt = 0;
    longint m_acc = 0, m_cnt = 0, m_num = 0, m_den = 0;
    bit     m_valid = 0, m_pub = 0;

    always #5 clk = ~clk;

    dcm_duty_meter #(.ACC_W(AW), .CNT_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .sample_en_i(sample_en_i), .mag_i(mag_i),
        .dump_i(dump_i), .acc_o(acc_o), .cnt_o(cnt_o), .num_o(num_o),
        .den_o(den_o), .res_valid_o(res_valid_o)
    );

    task automatic chk(string req, string field, longint act, longint exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, field, act, exp, cycles);
        end
    endtask

    task automatic compare_all();
        chk(phase, "acc_o", longint'(acc_o), m_acc);
        chk(phase, "cnt_o", longint'(cnt_o), m_cnt);
        chk("R9", "num_o", longint'(num_o), m_num);
        chk("R9", "den_o", longint'(den_o), m_den);
        chk("R10", "res_valid_o", longint'(res_valid_o), longint'(m_valid));
    endtask

    // one clock: check outputs, apply new inputs, advance model to next edge
    task automatic step(bit s, bit m, bit d);
        longint ns, nc;
        @(negedge clk);
        compare_all();
        sample_en_i = s;
        mag_i = m;
        dump_i = d;
        ns = m_live_sum;
        nc = m_live_cnt;
        if (s) begin
            ns = ns - (m ? 3 : 1);
            if (ns < FLOOR) ns = FLOOR;
            if (nc < CEIL) nc = nc + 1;
        end
        m_valid = m_pub;
        if (m_pub) begin
            m_num = -(m_cnt + m_acc);
            m_den = 2 * m_cnt;
        end
        m_pub = d;
        if (d) begin
            m_acc = ns;
            m_cnt = nc;
            m_live_sum = 0;
            m_live_cnt = 0;
        end else begin
            m_live_sum = ns;
            m_live_cnt = nc;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        // R1: reset values
        repeat (3) begin
            @(negedge clk);
            compare_all();
        end
        rst_n = 1'b1;
        repeat (3) step(0, 0, 0);

        // R2: only high samples
        phase = "R2";
        repeat (7) step(1, 1, 0);
        step(0, 0, 1);
        repeat (3) step(0, 0, 0);

        // R3: only low samples
        phase = "R3";
        repeat (9) step(1, 0, 0);
        step(0, 1, 1);
        repeat (3) step(0, 0, 0);

        // R4: magnitude toggles with no sample enable
        phase = "R4";
        repeat (4) step(1, 1, 0);
        for (int i = 0; i < 10; i++) step(0, i[0], 0);
        step(0, 0, 1);
        repeat (3) step(0, 0, 0);

        // R5: closing sample is taken on the dump cycle, next window restarts at zero
        phase = "R5";
        repeat (3) step(1, 0, 0);
        step(1, 1, 1);
        step(1, 1, 0);
        step(0, 0, 1);
        repeat (3) step(0, 0, 0);

        // R6: mixed pattern near 30 % duty
        phase = "R6";
        for (int i = 0; i < 100; i++) step(1, (i % 10) < 3, 0);
        step(1, 0, 1);
        for (int i = 0; i < 60; i++) step(i % 3 != 0, (i * 7) % 5 == 0, 0);
        step(0, 0, 1);
        repeat (3) step(0, 0, 0);

        // R7: sum reaches its floor
        phase = "R7";
        repeat (200) step(1, 1, 0);
        step(1, 1, 1);
        repeat (3) step(0, 0, 0);

        // R8: count reaches its ceiling
        phase = "R8";
        repeat (600) step(1, 0, 0);
        step(1, 0, 1);
        repeat (3) step(0, 0, 0);

        // R9 / R10: back-to-back dumps
        phase = "R10";
        step(1, 1, 1);
        step(1, 0, 1);
        step(1, 1, 1);
        step(0, 0, 0);
        step(1, 1, 0);
        step(1, 1, 1);
        repeat (4) step(0, 0, 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule